// File: doc/BRIEF.md
# USB IN Endpoint Transmit Buffer with Data Toggle

This block holds the outgoing data of one IN endpoint. Firmware fills a byte store through a small register bus, writes the packet length, then sets a release bit. The release bit clears itself one cycle later, and at that point the buffer belongs to the USB side. The USB side reads the bytes one at a time and sees the length and the data-toggle bit, which picks a DATA0 or DATA1 PID for the packet. While firmware owns the buffer, an IN token is answered with a NAK indication.

When the host acknowledges the packet, the toggle flips, ownership goes back to firmware and the byte pointers restart at zero. A timeout without acknowledge leaves the toggle and the data as they are, and rewinds the read pointer so that the packet can be sent again. Firmware can force the toggle only through a guarded write, in which an enable bit is set in the same write. A self-clearing flush returns the pointers, the length, the ownership, the pending bits and the toggle to their reset values.

Register map (addresses on `reg_addr`):
- 0: data. A write pushes one byte. Reads return 0.
- 1: length. It is read/write.
- 2: status. Bit 7 is the toggle, bit 3 is the overwrite enable (it always reads 0), and bit 0 is the USB-owns flag (read-only).
- 3: control. Bit 7 is flush and bit 4 is release. On a read, each bit shows whether its request is still pending.

Top module: `usb_in_ep_buf`

## Requirements
- R1: After reset the length reads 0, the status reads 0x00, the control reads 0x00 and `usb_ready` is 0.
- R2: Bytes written to address 0 while firmware owns the buffer are stored in order. After release, `usb_byte` shows byte 0, and each `usb_byte_req` pulse moves it to the next byte.
- R3: A write to address 1 while firmware owns the buffer sets the length, clamped to DEPTH. While the USB side owns the buffer, writes to addresses 0 and 1 and the release bit are ignored.
- R4: Writing control bit 4 makes that bit read 1 in the next cycle. One cycle later it reads 0 and `usb_ready` is 1.
- R5: `usb_nak` is 1 exactly when `in_token` is 1 and `usb_ready` is 0.
- R6: A `usb_ack` pulse while `usb_ready` is 1 flips `usb_seq` and clears `usb_ready`. The next load then starts again at byte 0.
- R7: A `usb_timeout` pulse while `usb_ready` is 1 keeps `usb_seq` and `usb_ready`, and rewinds `usb_byte` to byte 0.
- R8: A write to address 2 with bit 3 set loads `usb_seq` from bit 7. With bit 3 clear the toggle is unchanged, and status bit 3 always reads 0.
- R9: Writing control bit 7 makes that bit read 1 in the next cycle. One cycle later the length, the toggle, `usb_ready` and the control bits read 0, and the pointers restart at byte 0.
- R10: A guarded toggle write in the same cycle as an accepted ACK wins over the flip. A flush wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| in_token | input | 1 | IN token seen for this endpoint |
| usb_byte_req | input | 1 | Advance to the next byte |
| usb_ack | input | 1 | Valid ACK handshake received |
| usb_timeout | input | 1 | Transaction ended without ACK |
| usb_nak | output | 1 | Answer the IN token with NAK |
| usb_ready | output | 1 | USB side owns a released packet |
| usb_seq | output | 1 | Data toggle (0 = DATA0, 1 = DATA1) |
| usb_len | output | 7 | Packet length in bytes |
| usb_byte | output | 8 | Current byte to send |

## Verification
A toggle that flips at the wrong time shows up on `usb_seq` in the cycle after the faulty ACK, overwrite or flush. It is then read back through status bit 7. A wrong ownership state shows at once on `usb_nak` and `usb_ready`. A read pointer that fails to rewind or reset shows as a wrong `usb_byte` on the first byte of the next send or retry. Pending bits that do not self-clear keep reading 1 on the control register two cycles after the write.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

  localparam logic [1:0] RA_DATA  = 2'd0;
  localparam logic [1:0] RA_COUNT = 2'd1;
  localparam logic [1:0] RA_STAT  = 2'd2;
  localparam logic [1:0] RA_CTRL  = 2'd3;

  localparam int ST_SEQ_BIT   = 7;
  localparam int ST_OVW_BIT   = 3;
  localparam int ST_OWN_BIT   = 0;
  localparam int CT_FLUSH_BIT = 7;
  localparam int CT_REL_BIT   = 4;

  // Length written by firmware, limited to the store depth
  function automatic int unsigned clamp_len(input int unsigned v, input int unsigned depth);
    return (v > depth) ? depth : v;
  endfunction

  // Toggle update: clear beats forced value beats ACK flip
  function automatic logic next_toggle(input logic cur, input logic clr, input logic ovw,
                                       input logic ovw_val, input logic ack);
    if (clr)      return 1'b0;
    else if (ovw) return ovw_val;
    else if (ack) return ~cur;
    else          return cur;
  endfunction

  function automatic logic [7:0] pack_status(input logic seq, input logic owns);
    logic [7:0] r;
    r = 8'h00;
    r[ST_SEQ_BIT] = seq;
    r[ST_OWN_BIT] = owns;
    return r;
  endfunction

  function automatic logic [7:0] pack_ctrl(input logic flush_p, input logic rel_p);
    logic [7:0] r;
    r = 8'h00;
    r[CT_FLUSH_BIT] = flush_p;
    r[CT_REL_BIT]   = rel_p;
    return r;
  endfunction

endpackage

// File: rtl/ep_byte_store.sv
module ep_byte_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [PW-1:0] rd_limit,
  input  logic          ptr_clr,
  input  logic          rd_rewind,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr
);

  logic [DW-1:0] mem [DEPTH];
  logic          push_ok, pop_ok;

  assign push_ok = push && (wr_ptr < PW'(DEPTH));
  assign pop_ok  = pop  && (rd_ptr < rd_limit);

  always_ff @(posedge clk) begin
    if (push_ok && !ptr_clr) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (ptr_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok)        wr_ptr <= wr_ptr + 1'b1;
      if (rd_rewind)      rd_ptr <= '0;
      else if (pop_ok)    rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_data = (rd_ptr < PW'(DEPTH)) ? mem[rd_ptr[AW-1:0]] : '0;

endmodule

// File: rtl/ep_toggle.sv
module ep_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ovw,
  input  logic ovw_val,
  input  logic ack,
  output logic seq
);
  import usb_in_ep_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) seq <= 1'b0;
    else        seq <= next_toggle(seq, clr, ovw, ovw_val, ack);
  end

endmodule

// File: rtl/ep_owner_ctrl.sv
module ep_owner_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_release,
  input  logic req_flush,
  input  logic usb_ack,
  input  logic usb_timeout,
  output logic usb_owns,
  output logic rel_pend,
  output logic flush_pend,
  output logic ev_release,
  output logic ev_flush,
  output logic ev_ack,
  output logic ev_retry,
  output logic fw_can
);

  assign ev_flush   = flush_pend;
  assign ev_release = rel_pend && !flush_pend;
  assign ev_ack     = usb_ack && usb_owns && !flush_pend;
  assign ev_retry   = usb_timeout && usb_owns && !flush_pend && !usb_ack;
  assign fw_can     = !usb_owns && !rel_pend && !flush_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usb_owns   <= 1'b0;
      rel_pend   <= 1'b0;
      flush_pend <= 1'b0;
    end else if (ev_flush) begin
      usb_owns   <= 1'b0;
      rel_pend   <= 1'b0;
      flush_pend <= 1'b0;
    end else begin
      if (req_flush) flush_pend <= 1'b1;
      if (ev_release) begin
        rel_pend <= 1'b0;
        usb_owns <= 1'b1;
      end else if (req_release && fw_can && !req_flush) begin
        rel_pend <= 1'b1;
      end
      if (ev_ack) usb_owns <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             in_token,
  input  logic             usb_byte_req,
  input  logic             usb_ack,
  input  logic             usb_timeout,
  output logic             usb_nak,
  output logic             usb_ready,
  output logic             usb_seq,
  output logic [CNT_W-1:0] usb_len,
  output logic [DW-1:0]    usb_byte
);
  import usb_in_ep_pkg::*;

  logic             usb_owns, rel_pend, flush_pend, fw_can;
  logic             ev_release, ev_flush, ev_ack, ev_retry, ev_ovw;
  logic             wr_data, wr_cnt, wr_stat, wr_ctl;
  logic             seq;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wr_ptr, rd_ptr;

  assign wr_data = reg_wr && (reg_addr == RA_DATA);
  assign wr_cnt  = reg_wr && (reg_addr == RA_COUNT);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_ctl  = reg_wr && (reg_addr == RA_CTRL);
  assign ev_ovw  = wr_stat && reg_wdata[ST_OVW_BIT];

  ep_owner_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_release (wr_ctl && reg_wdata[CT_REL_BIT]),
    .req_flush   (wr_ctl && reg_wdata[CT_FLUSH_BIT] && !flush_pend),
    .usb_ack     (usb_ack),
    .usb_timeout (usb_timeout),
    .usb_owns    (usb_owns),
    .rel_pend    (rel_pend),
    .flush_pend  (flush_pend),
    .ev_release  (ev_release),
    .ev_flush    (ev_flush),
    .ev_ack      (ev_ack),
    .ev_retry    (ev_retry),
    .fw_can      (fw_can)
  );

  ep_byte_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_data && fw_can),
    .push_data (reg_wdata[DW-1:0]),
    .pop       (usb_byte_req && usb_owns),
    .rd_limit  (cnt_q),
    .ptr_clr   (ev_flush || ev_ack),
    .rd_rewind (ev_release || ev_retry),
    .rd_data   (usb_byte),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
  );

  ep_toggle u_toggle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ev_flush),
    .ovw     (ev_ovw),
    .ovw_val (reg_wdata[ST_SEQ_BIT]),
    .ack     (ev_ack),
    .seq     (seq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (ev_flush)         cnt_q <= '0;
    else if (wr_cnt && fw_can) cnt_q <= CNT_W'(clamp_len(32'(reg_wdata), DEPTH));
  end

  always_comb begin
    unique case (reg_addr)
      RA_COUNT: reg_rdata = 8'(cnt_q);
      RA_STAT:  reg_rdata = pack_status(seq, usb_owns);
      RA_CTRL:  reg_rdata = pack_ctrl(flush_pend, rel_pend);
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign usb_nak   = in_token && !usb_owns;
  assign usb_ready = usb_owns;
  assign usb_seq   = seq;
  assign usb_len   = cnt_q;

endmodule

// File: rtl/usb_in_ep_buf_chk.sv
module usb_in_ep_buf_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             usb_owns,
  input logic             seq,
  input logic             ev_ack,
  input logic             ev_ovw,
  input logic             ev_flush,
  input logic             flush_pend,
  input logic             rel_pend,
  input logic             in_token,
  input logic             usb_nak,
  input logic [CNT_W-1:0] usb_len
);

  a_r6_seq_flips_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack && !ev_ovw && !flush_pend) |=> (seq != $past(seq)));

  a_r8_seq_holds_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_ack && !ev_ovw && !ev_flush) |=> $stable(seq));

  a_r5_nak_when_unowned: assert property (@(posedge clk) disable iff (!rst_n)
    usb_nak |-> (in_token && !usb_owns));

  a_r4_release_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_pend && !flush_pend) |=> (!rel_pend && usb_owns));

  a_r9_flush_resets: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pend |=> (!flush_pend && !usb_owns && !seq && usb_len == '0));

  a_r6_ack_returns_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack |=> !usb_owns);

  a_r3_len_frozen_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_owns && !flush_pend) |=> $stable(usb_len));

endmodule

bind usb_in_ep_buf usb_in_ep_buf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .usb_owns   (usb_owns),
  .seq        (seq),
  .ev_ack     (ev_ack),
  .ev_ovw     (ev_ovw),
  .ev_flush   (ev_flush),
  .flush_pend (flush_pend),
  .rel_pend   (rel_pend),
  .in_token   (in_token),
  .usb_nak    (usb_nak),
  .usb_len    (usb_len)
);

// File: tb/tb_usb_in_ep_buf.sv
module tb_usb_in_ep_buf;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n, reg_wr, in_token, usb_byte_req, usb_ack, usb_timeout;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata, usb_byte;
  logic       usb_nak, usb_ready, usb_seq;
  logic [6:0] usb_len;

  int checks = 0;
  int errors = 0;
  logic       exp_seq;
  logic [7:0] exp_mem [DEPTH];
  int         exp_cnt;

  always #5 clk = ~clk;

  usb_in_ep_buf dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_token(in_token),
    .usb_byte_req(usb_byte_req), .usb_ack(usb_ack), .usb_timeout(usb_timeout),
    .usb_nak(usb_nak), .usb_ready(usb_ready), .usb_seq(usb_seq),
    .usb_len(usb_len), .usb_byte(usb_byte)
  );

  // Bench view of the register layout
  function automatic logic [7:0] stat_of(input logic s, input logic own);
    return {s, 6'b0, own};
  endfunction
  function automatic int clamp(input int v);
    return (v > DEPTH) ? DEPTH : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic pop(output logic [7:0] b);
    b = usb_byte; usb_byte_req = 1'b1;
    @(negedge clk);
    usb_byte_req = 1'b0;
  endtask

  task automatic release_buf();
    logic [7:0] v;
    wr(2'd3, 8'h10);
    rd(2'd3, v); chk("R4 release pending", int'(v), 32'h10);
    tick();
    rd(2'd3, v); chk("R4 release cleared", int'(v), 0);
    chk("R4 ready", int'(usb_ready), 1);
  endtask

  task automatic load_random(input int n);
    for (int i = 0; i < n; i++) begin
      exp_mem[i] = 8'($urandom);
      wr(2'd0, exp_mem[i]);
    end
    wr(2'd1, 8'(n));
    exp_cnt = n;
  endtask

  task automatic send_all(input string req);
    logic [7:0] b;
    chk("R2 length", int'(usb_len), exp_cnt);
    chk("R6 toggle before send", int'(usb_seq), int'(exp_seq));
    for (int i = 0; i < exp_cnt; i++) begin
      pop(b); chk(req, int'(b), int'(exp_mem[i]));
    end
  endtask

  task automatic ack();
    usb_ack = 1'b1; tick(); usb_ack = 1'b0;
    exp_seq = ~exp_seq;
    chk("R6 toggle flipped", int'(usb_seq), int'(exp_seq));
    chk("R6 ownership back", int'(usb_ready), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, b;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    in_token = 0; usb_byte_req = 0; usb_ack = 0; usb_timeout = 0;
    exp_seq = 0; exp_cnt = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();

    // R1 reset state
    rd(2'd1, v); chk("R1 length", int'(v), 0);
    rd(2'd2, v); chk("R1 status", int'(v), 0);
    rd(2'd3, v); chk("R1 control", int'(v), 0);
    chk("R1 ready", int'(usb_ready), 0);

    // R5 NAK while firmware owns
    in_token = 1; #1; chk("R5 nak unowned", int'(usb_nak), 1); in_token = 0; #1;
    chk("R5 no token no nak", int'(usb_nak), 0);

    // R3 clamp
    wr(2'd1, 8'd200); rd(2'd1, v); chk("R3 clamp", int'(v), clamp(200));

    // R2 known bytes, then R3 ignored writes while owned
    exp_mem[0] = 8'h21; exp_mem[1] = 8'h42; exp_mem[2] = 8'h11;
    for (int i = 0; i < 3; i++) wr(2'd0, exp_mem[i]);
    wr(2'd1, 8'd3); exp_cnt = 3;
    release_buf();
    in_token = 1; #1; chk("R5 no nak when owned", int'(usb_nak), 0); in_token = 0;
    send_all("R2 byte order");
    ack();
    exp_mem[0] = 8'h5a; exp_mem[1] = 8'h3c;
    wr(2'd0, 8'h5a); wr(2'd0, 8'h3c); wr(2'd1, 8'd3);
    release_buf();
    wr(2'd0, 8'ha5); wr(2'd1, 8'd5); wr(2'd3, 8'h10);
    rd(2'd1, v); chk("R3 length ignored when owned", int'(v), 3);
    rd(2'd3, v); chk("R3 release ignored when owned", int'(v), 0);
    send_all("R3 data ignored when owned");
    ack();

    // R7 timeout retry
    load_random(5);
    release_buf();
    pop(b); pop(b);
    usb_timeout = 1; tick(); usb_timeout = 0;
    chk("R7 ready kept", int'(usb_ready), 1);
    chk("R7 toggle kept", int'(usb_seq), int'(exp_seq));
    chk("R7 rewound", int'(usb_byte), int'(exp_mem[0]));
    send_all("R7 retry data");
    ack();

    // R8 guarded overwrite
    wr(2'd2, {~exp_seq, 7'h00});
    chk("R8 unguarded ignored", int'(usb_seq), int'(exp_seq));
    wr(2'd2, {~exp_seq, 7'h08}); exp_seq = ~exp_seq;
    rd(2'd2, v); chk("R8 guarded write", int'(v), int'(stat_of(exp_seq, 1'b0)));
    chk("R8 enable reads 0", int'(v[3]), 0);

    // R10 overwrite beats ACK in the same cycle
    load_random(2); release_buf();
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = {exp_seq, 7'h08}; usb_ack = 1;
    tick(); reg_wr = 0; usb_ack = 0;
    chk("R10 overwrite wins", int'(usb_seq), int'(exp_seq));
    chk("R10 ack still releases", int'(usb_ready), 0);

    // R9 flush while owned, toggle set
    wr(2'd2, 8'h88); exp_seq = 1;
    load_random(4); release_buf();
    wr(2'd3, 8'h80);
    rd(2'd3, v); chk("R9 flush pending", int'(v), 32'h80);
    usb_ack = 1; tick(); usb_ack = 0;
    rd(2'd3, v); chk("R9 flush cleared", int'(v), 0);
    rd(2'd1, v); chk("R9 length cleared", int'(v), 0);
    rd(2'd2, v); chk("R10 R9 status after flush", int'(v), 0);
    exp_seq = 0;
    load_random(3); release_buf();
    send_all("R9 pointers restart");
    ack();

    // Random traffic
    for (int it = 0; it < 40; it++) begin
      int n;
      n = 1 + int'($urandom % DEPTH);
      if ($urandom % 4 == 0) begin
        logic nv;
        nv = 1'($urandom);
        wr(2'd2, {nv, 7'h08}); exp_seq = nv;
      end
      load_random(n);
      release_buf();
      if ($urandom % 3 == 0) begin
        for (int k = 0; k < int'($urandom % n); k++) pop(b);
        usb_timeout = 1; tick(); usb_timeout = 0;
        chk("R7 random rewind", int'(usb_byte), int'(exp_mem[0]));
      end
      send_all("R2 random data");
      ack();
      rd(2'd2, v); chk("R6 random status", int'(v), int'(stat_of(exp_seq, 1'b0)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule